// File: doc/BRIEF.md
# Transmit Frame Serializer

This block turns a frame stored in a byte buffer into a serial bit stream for a load-modulation transmitter. A one-cycle `start` pulse latches the frame options and the length. The block then reads payload bytes from the buffer by address and sends one bit per clock on `tx_bit`, qualified by `tx_valid`. Modulation coding is done downstream.

The payload length is given as a count of whole bytes plus a count of 0 to 7 extra bits. The extra bits form a partial byte. That partial byte is either the last byte read, which keeps its low bits, or the first byte read, which keeps its high bits. Each option can be switched on or off on its own: a leading start-of-frame bit, an odd parity bit after every whole byte, and a 16-bit CRC over the payload. A pulse on `evt_start` marks the first bit sent and a pulse on `evt_end` marks the finished frame.

Top module: `txf_serializer`

## Requirements
- R1: After reset, and after a reset applied in the middle of a frame, `busy`, `tx_valid`, `evt_start` and `evt_end` are all low.
- R2: When `start` is sampled high while idle, bits appear on `tx_valid`/`tx_bit` from the next cycle, one per cycle with no gaps. Each whole byte is read from ascending addresses beginning at 0 and is sent least-significant bit first.
- R3: With `cfg_sof`=1, a single bit of value 1 precedes the payload.
- R4: With `cfg_parity`=1, every whole byte (payload and CRC) is followed by one odd-parity bit, so each 8 data bits plus parity hold an odd number of ones. A partial byte gets no parity bit.
- R5: With `cfg_crc`=1 and a non-empty payload, a CRC is appended after the payload. It uses the polynomial x^16+x^12+x^5+1, is processed bit-reflected, starts from 0x6363, and covers the payload data bits only. It is sent low byte first, each byte least-significant bit first. Two zero bytes give the CRC bytes 0xA0 then 0x1E.
- R6: With `cfg_disc_start`=0 and `len_bits`=N>0, after the whole bytes the block sends bits 0..N-1 of the byte at address `len_bytes`.
- R7: With `cfg_disc_start`=1 and `len_bits`=N>0, the first byte read, at address 0, supplies only its bits 8-N..7, sent in that order. The whole bytes follow from addresses 1..`len_bytes`.
- R8: `evt_start` is high for exactly one cycle, the cycle of the first transmitted bit.
- R9: `evt_end` is high for one cycle, the cycle after the last bit, with `tx_valid` low. `busy` is low in the following cycle.
- R10: A frame with zero bytes and zero bits sends only the start-of-frame bit if enabled, and no CRC, and then raises `evt_end`. With no start-of-frame bit it raises `evt_end` in the first cycle after `start`.
- R11: A `start` pulse, or a change of configuration or length, while `busy` is high does not alter the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (accepted only when idle) |
| cfg_parity | input | 1 | Insert odd parity after each whole byte |
| cfg_sof | input | 1 | Send a start-of-frame bit |
| cfg_crc | input | 1 | Append a 16-bit CRC |
| cfg_disc_start | input | 1 | Partial byte is the first byte (1) or the last byte (0) |
| len_bytes | input | CNT_W | Number of whole payload bytes |
| len_bits | input | 3 | Bits in the partial byte (0 = none) |
| rd_addr | output | CNT_W+1 | Buffer byte address |
| rd_data | input | 8 | Buffer byte at `rd_addr`, same cycle |
| tx_valid | output | 1 | `tx_bit` carries a frame bit this cycle |
| tx_bit | output | 1 | Serial frame bit |
| evt_start | output | 1 | First bit of the frame |
| evt_end | output | 1 | Frame complete |
| busy | output | 1 | Frame in progress |

## Verification
A wrong bit position or segment pointer shows at once as a wrong `tx_bit` in the same cycle, so the bench compares every bit of each frame against a model built from the requirements. A miscounted whole-byte or partial-bit counter changes the frame length, which appears in the cycle `evt_end` rises. A corrupt CRC register stays hidden until the last 16 or 18 bits of the frame. For that reason the CRC is also checked against a known value for two zero bytes, and not only against the bench's own bitwise model.

// File: rtl/txf_pkg.sv
package txf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SOF,
        ST_DATA,
        ST_PAR,
        ST_CRC,
        ST_CPAR,
        ST_DONE
    } txf_state_e;

    typedef struct packed {
        logic parity;
        logic sof;
        logic crc;
        logic disc_start;
    } txf_cfg_t;

    // One byte's worth of bits to send: which bit positions, whole or partial
    typedef struct packed {
        logic       ok;
        logic       whole;
        logic [2:0] first_pos;
        logic [2:0] last_pos;
    } txf_seg_t;

    localparam logic [15:0] CRC_POLY_REFL = 16'h8408;
    localparam logic [15:0] CRC_SEED      = 16'h6363;

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic d);
        logic [15:0] n;
        n = {1'b0, c[15:1]};
        if (c[0] ^ d) n = n ^ CRC_POLY_REFL;
        return n;
    endfunction

    function automatic logic odd_par(input logic [7:0] b);
        return ~(^b);
    endfunction

endpackage

// File: rtl/txf_crc16.sv
module txf_crc16
    import txf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        en,
    input  logic        din,
    output logic [15:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || clr) crc <= CRC_SEED;
        else if (en)    crc <= crc_step(crc, din);
    end
endmodule

// File: rtl/txf_seg_pick.sv
module txf_seg_pick
    import txf_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] whole_left,
    input  logic             part_end,
    input  logic [2:0]       part_bits,
    output txf_seg_t         seg,
    output logic [CNT_W-1:0] whole_left_nxt,
    output logic             part_end_nxt
);
    always_comb begin
        seg            = '0;
        whole_left_nxt = whole_left;
        part_end_nxt   = part_end;
        if (whole_left != '0) begin
            seg            = '{ok: 1'b1, whole: 1'b1, first_pos: 3'd0, last_pos: 3'd7};
            whole_left_nxt = whole_left - CNT_W'(1);
        end else if (part_end) begin
            seg          = '{ok: 1'b1, whole: 1'b0, first_pos: 3'd0, last_pos: part_bits - 3'd1};
            part_end_nxt = 1'b0;
        end
    end
endmodule

// File: rtl/txf_serializer.sv
module txf_serializer
    import txf_pkg::*;
#(
    parameter int CNT_W = 8,
    localparam int ADDR_W = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              cfg_parity,
    input  logic              cfg_sof,
    input  logic              cfg_crc,
    input  logic              cfg_disc_start,
    input  logic [CNT_W-1:0]  len_bytes,
    input  logic [2:0]        len_bits,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              tx_valid,
    output logic              tx_bit,
    output logic              evt_start,
    output logic              evt_end,
    output logic              busy
);
    txf_state_e        state;
    txf_cfg_t          cfg_q;
    txf_seg_t          seg;
    logic [CNT_W-1:0]  whole_left;
    logic              part_end;
    logic [2:0]        part_bits_q;
    logic [ADDR_W-1:0] addr;
    logic [2:0]        bitpos;
    logic [3:0]        crc_cnt;
    logic              has_data;
    logic              first;
    logic [15:0]       crc_val;

    logic              accept;
    logic [CNT_W-1:0]  pick_wl_in, pick_wl_nxt;
    logic              pick_pe_in, pick_pe_nxt;
    logic [2:0]        pick_bits_in;
    txf_seg_t          pick_seg, start_seg;
    txf_state_e        adv_state;

    assign accept = (state == ST_IDLE) && start;

    // On acceptance the picker looks at the port values, otherwise at the saved counters
    assign pick_wl_in   = accept ? len_bytes : whole_left;
    assign pick_pe_in   = accept ? ((len_bits != 3'd0) && !cfg_disc_start) : part_end;
    assign pick_bits_in = accept ? len_bits : part_bits_q;

    txf_seg_pick #(.CNT_W(CNT_W)) u_pick (
        .whole_left     (pick_wl_in),
        .part_end       (pick_pe_in),
        .part_bits      (pick_bits_in),
        .seg            (pick_seg),
        .whole_left_nxt (pick_wl_nxt),
        .part_end_nxt   (pick_pe_nxt)
    );

    txf_crc16 u_crc (
        .clk (clk),
        .rst (rst),
        .clr (accept),
        .en  (state == ST_DATA),
        .din (tx_bit),
        .crc (crc_val)
    );

    always_comb begin
        if (cfg_disc_start && (len_bits != 3'd0))
            start_seg = '{ok: 1'b1, whole: 1'b0, first_pos: 3'(4'd8 - {1'b0, len_bits}), last_pos: 3'd7};
        else
            start_seg = pick_seg;
    end

    // Where to go once the current byte (and its parity) is finished
    always_comb begin
        if (pick_seg.ok)       adv_state = ST_DATA;
        else if (cfg_q.crc)    adv_state = ST_CRC;
        else                   adv_state = ST_DONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            cfg_q       <= '0;
            seg         <= '0;
            whole_left  <= '0;
            part_end    <= 1'b0;
            part_bits_q <= '0;
            addr        <= '0;
            bitpos      <= '0;
            crc_cnt     <= '0;
            has_data    <= 1'b0;
            first       <= 1'b0;
        end else begin
            if (tx_valid) first <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    cfg_q       <= '{parity: cfg_parity, sof: cfg_sof, crc: cfg_crc, disc_start: cfg_disc_start};
                    part_bits_q <= len_bits;
                    seg         <= start_seg;
                    bitpos      <= start_seg.first_pos;
                    has_data    <= start_seg.ok;
                    addr        <= '0;
                    crc_cnt     <= '0;
                    first       <= 1'b1;
                    if (cfg_disc_start && (len_bits != 3'd0)) begin
                        whole_left <= len_bytes;
                        part_end   <= 1'b0;
                    end else begin
                        whole_left <= pick_wl_nxt;
                        part_end   <= pick_pe_nxt;
                    end
                    if (cfg_sof)           state <= ST_SOF;
                    else if (start_seg.ok) state <= ST_DATA;
                    else                   state <= ST_DONE;
                end
                ST_SOF: state <= has_data ? ST_DATA : ST_DONE;
                ST_DATA: begin
                    if (bitpos != seg.last_pos) begin
                        bitpos <= bitpos + 3'd1;
                    end else if (seg.whole && cfg_q.parity) begin
                        state <= ST_PAR;
                    end else begin
                        addr       <= addr + ADDR_W'(1);
                        seg        <= pick_seg;
                        bitpos     <= pick_seg.first_pos;
                        whole_left <= pick_wl_nxt;
                        part_end   <= pick_pe_nxt;
                        state      <= adv_state;
                    end
                end
                ST_PAR: begin
                    addr       <= addr + ADDR_W'(1);
                    seg        <= pick_seg;
                    bitpos     <= pick_seg.first_pos;
                    whole_left <= pick_wl_nxt;
                    part_end   <= pick_pe_nxt;
                    state      <= adv_state;
                end
                ST_CRC: begin
                    if (crc_cnt[2:0] == 3'd7 && cfg_q.parity) state <= ST_CPAR;
                    else if (crc_cnt == 4'd15)                state <= ST_DONE;
                    else                                      crc_cnt <= crc_cnt + 4'd1;
                end
                ST_CPAR: begin
                    if (crc_cnt == 4'd15) state <= ST_DONE;
                    else begin
                        crc_cnt <= crc_cnt + 4'd1;
                        state   <= ST_CRC;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (state)
            ST_SOF:  tx_bit = 1'b1;
            ST_DATA: tx_bit = rd_data[bitpos];
            ST_PAR:  tx_bit = odd_par(rd_data);
            ST_CRC:  tx_bit = crc_val[crc_cnt];
            ST_CPAR: tx_bit = odd_par(crc_cnt[3] ? crc_val[15:8] : crc_val[7:0]);
            default: tx_bit = 1'b0;
        endcase
    end

    assign tx_valid  = (state != ST_IDLE) && (state != ST_DONE);
    assign evt_start = tx_valid && first;
    assign evt_end   = (state == ST_DONE);
    assign busy      = (state != ST_IDLE);
    assign rd_addr   = addr;

    // R8: start event only with a bit, and never two cycles running
    a_r8_start_with_bit: assert property (@(posedge clk) disable iff (rst)
        evt_start |-> tx_valid);
    a_r8_start_once: assert property (@(posedge clk) disable iff (rst)
        evt_start |=> !evt_start);
    // R9: end event is a single pulse without a bit, then idle
    a_r9_end_no_bit: assert property (@(posedge clk) disable iff (rst)
        evt_end |-> !tx_valid);
    a_r9_end_then_idle: assert property (@(posedge clk) disable iff (rst)
        evt_end |=> (!evt_end && !busy));
    // R11: a start request during a frame never restarts it
    a_r11_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> !evt_start);
    // R4: a parity bit only follows a finished whole byte
    a_r4_par_after_whole: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PAR) |-> ($past(state) == ST_DATA && seg.whole && cfg_q.parity));
    // R5: the CRC value is frozen while it is being shifted out
    a_r5_crc_frozen: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CRC && $past(state) == ST_CRC) |-> $stable(crc_val));

endmodule

// File: tb/txf_serializer_tb.sv
`timescale 1ns/1ps
module txf_serializer_tb;
    localparam int CNT_W  = 8;
    localparam int ADDR_W = CNT_W + 1;
    localparam int NV     = 10;
    localparam int MAXB   = 1024;

    // vector fields: [14] parity [13] sof [12] crc [11] disc_start [10:3] bytes [2:0] bits
    localparam logic [14:0] VEC [NV] = '{
        {1'b1, 1'b1, 1'b1, 1'b0, 8'd4,  3'd0},
        {1'b0, 1'b0, 1'b0, 1'b0, 8'd3,  3'd0},
        {1'b1, 1'b0, 1'b0, 1'b0, 8'd2,  3'd5},
        {1'b1, 1'b1, 1'b1, 1'b1, 8'd3,  3'd3},
        {1'b0, 1'b1, 1'b1, 1'b0, 8'd0,  3'd4},
        {1'b0, 1'b0, 1'b1, 1'b1, 8'd0,  3'd7},
        {1'b1, 1'b1, 1'b0, 1'b0, 8'd1,  3'd0},
        {1'b0, 1'b1, 1'b0, 1'b0, 8'd0,  3'd0},
        {1'b0, 1'b0, 1'b1, 1'b0, 8'd0,  3'd0},
        {1'b1, 1'b0, 1'b1, 1'b0, 8'd16, 3'd1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic cfg_parity = 1'b0, cfg_sof = 1'b0, cfg_crc = 1'b0, cfg_disc_start = 1'b0;
    logic [CNT_W-1:0] len_bytes = '0;
    logic [2:0] len_bits = '0;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0] rd_data;
    logic tx_valid, tx_bit, evt_start, evt_end, busy;

    logic [7:0] mem [0:(1<<ADDR_W)-1];
    logic exp_bits [0:MAXB-1];
    logic got_bits [0:MAXB-1];
    int exp_n, got_n;
    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;
    assign rd_data = mem[rd_addr];

    txf_serializer #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .start(start),
        .cfg_parity(cfg_parity), .cfg_sof(cfg_sof), .cfg_crc(cfg_crc),
        .cfg_disc_start(cfg_disc_start), .len_bytes(len_bytes), .len_bits(len_bits),
        .rd_addr(rd_addr), .rd_data(rd_data), .tx_valid(tx_valid), .tx_bit(tx_bit),
        .evt_start(evt_start), .evt_end(evt_end), .busy(busy)
    );

    function automatic string vtag(int i);
        case (i)
            0: return "R5";
            1: return "R2";
            2: return "R6";
            3: return "R7";
            4: return "R3";
            5: return "R7";
            6: return "R4";
            7: return "R10";
            8: return "R10";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic b);
        exp_bits[exp_n] = b;
        exp_n++;
    endtask

    // Expected frame built directly from the requirements
    task automatic build_exp(input logic par, input logic sof, input logic crc, input logic dst,
                             input int nb, input int nbits);
        logic [15:0] c;
        logic [7:0] byt;
        int ndata;
        exp_n = 0;
        ndata = 0;
        c = 16'h6363;
        if (sof) push(1'b1);
        if (dst && nbits != 0) begin
            for (int k = 8 - nbits; k < 8; k++) begin
                push(mem[0][k]);
                if (c[0] ^ mem[0][k]) c = (c >> 1) ^ 16'h8408; else c = c >> 1;
                ndata++;
            end
        end
        for (int i = 0; i < nb; i++) begin
            byt = mem[(dst && nbits != 0) ? i + 1 : i];
            for (int k = 0; k < 8; k++) begin
                push(byt[k]);
                if (c[0] ^ byt[k]) c = (c >> 1) ^ 16'h8408; else c = c >> 1;
                ndata++;
            end
            if (par) push(~(^byt));
        end
        if (!dst && nbits != 0) begin
            for (int k = 0; k < nbits; k++) begin
                push(mem[nb][k]);
                if (c[0] ^ mem[nb][k]) c = (c >> 1) ^ 16'h8408; else c = c >> 1;
                ndata++;
            end
        end
        if (crc && ndata > 0) begin
            for (int h = 0; h < 2; h++) begin
                byt = (h == 0) ? c[7:0] : c[15:8];
                for (int k = 0; k < 8; k++) push(byt[k]);
                if (par) push(~(^byt));
            end
        end
    endtask

    // Launch one frame and capture it; poke=1 disturbs the inputs mid-frame
    task automatic run_frame(input logic par, input logic sof, input logic crc, input logic dst,
                             input int nb, input int nbits, input string tag, input bit poke);
        int cyc, es_cnt, es_pos;
        bit ended, gap;
        int mism;
        build_exp(par, sof, crc, dst, nb, nbits);
        @(negedge clk);
        cfg_parity = par; cfg_sof = sof; cfg_crc = crc; cfg_disc_start = dst;
        len_bytes = CNT_W'(nb); len_bits = 3'(nbits);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got_n = 0; cyc = 0; es_cnt = 0; es_pos = -1; ended = 0; gap = 0;
        while (!ended && cyc < 4000) begin
            if (tx_valid) begin
                if (evt_start) begin es_cnt++; es_pos = got_n; end
                if (got_n < MAXB) got_bits[got_n] = tx_bit;
                got_n++;
            end else if (evt_end) ended = 1;
            else gap = 1;
            if (!ended) begin
                @(negedge clk);
                cyc++;
                if (poke && cyc == 5) begin
                    start = 1'b1; cfg_parity = ~par; cfg_sof = ~sof; cfg_crc = ~crc;
                    cfg_disc_start = ~dst; len_bytes = 8'd1; len_bits = 3'd2;
                end else if (poke && cyc == 6) start = 1'b0;
            end
        end
        start = 1'b0;
        check(got_n == exp_n, tag, "frame length", got_n, exp_n);
        mism = -1;
        for (int i = 0; i < exp_n && i < got_n; i++)
            if (mism < 0 && got_bits[i] !== exp_bits[i]) mism = i;
        check(mism < 0, tag, "first mismatching bit index", mism, -1);
        check(es_cnt == ((exp_n > 0) ? 1 : 0) && (es_cnt == 0 || es_pos == 0),
              "R8", "start event count", es_cnt, (exp_n > 0) ? 1 : 0);
        check(ended && !gap, "R9", "end event after last bit", int'(ended && !gap), 1);
        @(negedge clk);
        check(!busy && !evt_end, "R9", "idle after end event", int'(busy), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R9 watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] crcv;
        for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = 8'((i * 37) ^ 8'hA5);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(!busy && !tx_valid && !evt_start && !evt_end, "R1", "reset outputs",
              int'({busy, tx_valid, evt_start, evt_end}), 0);

        for (int v = 0; v < NV; v++)
            run_frame(VEC[v][14], VEC[v][13], VEC[v][12], VEC[v][11],
                      int'(VEC[v][10:3]), int'(VEC[v][2:0]), vtag(v), 1'b0);

        // R11: disturbance during a frame has no effect
        run_frame(1'b1, 1'b0, 1'b1, 1'b0, 5, 2, "R11", 1'b1);

        // R5: known CRC value for two zero bytes
        mem[0] = 8'h00; mem[1] = 8'h00;
        run_frame(1'b0, 1'b0, 1'b1, 1'b0, 2, 0, "R5", 1'b0);
        crcv = '0;
        for (int k = 0; k < 16; k++) crcv[k] = got_bits[16 + k];
        check(crcv == 16'h1EA0, "R5", "crc of two zero bytes", int'(crcv), 32'h1EA0);

        // R2: plain bytes sent LSB first from ascending addresses
        mem[0] = 8'h01; mem[1] = 8'h80;
        run_frame(1'b0, 1'b0, 1'b0, 1'b0, 2, 0, "R2", 1'b0);
        check(got_bits[0] == 1'b1 && got_bits[15] == 1'b1 && got_bits[7] == 1'b0,
              "R2", "lsb first order", int'({got_bits[0], got_bits[7], got_bits[15]}), 3'b101);

        // R1: reset in the middle of a frame
        @(negedge clk);
        cfg_parity = 1'b0; cfg_sof = 1'b1; cfg_crc = 1'b0; cfg_disc_start = 1'b0;
        len_bytes = 8'd6; len_bits = 3'd0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(!busy && !tx_valid && !evt_end, "R1", "mid-frame reset", int'({busy, tx_valid, evt_end}), 0);
        @(negedge clk);
        check(!busy && !tx_valid, "R1", "stays idle after reset", int'({busy, tx_valid}), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule